// File: doc/BRIEF.md
# USB Receive Endpoint DMA Unloader

This block sits between one USB receive endpoint FIFO and a DMA engine. When a received packet is signalled, it latches the packet's byte count and marks the endpoint ready. It then raises a burst request, so the DMA engine can drain the packet as 32-bit words. The FIFO is always read in whole words. The number of word reads per packet is fixed by the configured maximum packet size rounded up to a multiple of four. It does not depend on how many bytes actually arrived.

After the last word of a packet, the block decides whether the ready flag clears on its own. It clears only when the packet occupies as many words as a maximum-size packet. Otherwise the flag stays set until software clears it. The block reports how many padding bytes were read past the real packet end. A remaining-length counter is loaded with the total transfer length and reduced by the rounded packet size after each packet. An interrupt pulse is raised either after every packet or only when the whole transfer is done, as chosen by a mode input. Once fewer bytes remain than one rounded packet, DMA service stops and the data is left for programmed I/O.

Top module: `rxdu_top`

## Requirements
- R1: `burst_req` is high only while `dma_en` is high, `rx_ready` is high, words of the current packet remain unread, and the remaining transfer length is at least the rounded packet size. The rounded packet size is `max_pkt` rounded up to a multiple of 4.
- R2: Each accepted packet is drained by exactly ceil(`max_pkt`/4) reads. A read is a clock with `word_rd` and `burst_req` both high. After the last read `burst_req` is low.
- R3: Each completed packet reduces the remaining length by the rounded packet size, not by the received byte count.
- R4: At the last read, `rx_ready` clears on the next edge only when ceil(`pkt_bytes`/4) equals ceil(`max_pkt`/4). Otherwise it stays high.
- R5: `sw_clr` clears `rx_ready` and discards any unread words of the packet, taking priority over a read in the same clock.
- R6: One clock after the last read, `pad_cnt` shows the rounded packet size minus the packet's byte count. It holds that value until the next packet completes.
- R7: With `dma_mode` = 0, `irq` is a one-clock pulse in the clock after every packet's last read.
- R8: With `dma_mode` = 1, `irq` pulses only after the packet that brings the remaining length to zero.
- R9: When the remaining length is below the rounded packet size, a ready packet raises no request and `rx_ready` stays high.
- R10: With `dma_en` low, `burst_req` is low in the same clock. `word_rd` is ignored and no interrupt results.
- R11: During and right after reset, `burst_req`, `rx_ready`, `irq` and `pad_cnt` are all zero, and the remaining length is zero.
- R12: A `pkt_valid` pulse while `rx_ready` is high is ignored. The held packet's byte count is kept.
- R13: `xfer_start` loads `xfer_len` as the remaining length, taking priority over a packet completion in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| max_pkt | input | CNT_W | Configured maximum packet size in bytes |
| pkt_valid | input | 1 | One-clock pulse: a packet has been received |
| pkt_bytes | input | CNT_W | Byte count of the received packet, valid with `pkt_valid` |
| sw_clr | input | 1 | Software clear of the ready flag |
| dma_en | input | 1 | DMA service enable for the endpoint |
| dma_mode | input | 1 | 0: interrupt per packet, 1: interrupt at transfer end |
| xfer_start | input | 1 | Load pulse for the transfer length |
| xfer_len | input | LEN_W | Total transfer length in bytes |
| word_rd | input | 1 | DMA engine reads one 32-bit word |
| burst_req | output | 1 | Burst request to the DMA engine |
| rx_ready | output | 1 | Endpoint FIFO holds a packet |
| pad_cnt | output | CNT_W+1 | Bytes read past the last packet's end |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that `max_pkt` only changes while no packet is held. They also assume that `pkt_bytes` never exceeds `max_pkt` and that `max_pkt` is not zero. The bench only changes the maximum size between packets, after `rx_ready` has cleared. It keeps every packet length within that bound. Packets are sized on both sides of the word-count boundary for maximum sizes with remainders 0, 1 and 2 modulo 4. Disable, software clear and repeated ready pulses are placed in the middle of bursts.

// File: rtl/rxdu_pkg.sv
package rxdu_pkg;

  typedef enum logic {
    IRQ_PER_PKT  = 1'b0,
    IRQ_END_XFER = 1'b1
  } irq_mode_e;

  typedef struct packed {
    logic fire;
    logic self_clr;
  } pkt_end_t;

endpackage

// File: rtl/rxdu_size_calc.sv
module rxdu_size_calc #(
  parameter int CNT_W = 11
) (
  input  logic [CNT_W-1:0] max_pkt,
  input  logic [CNT_W-1:0] pkt_len,
  output logic [CNT_W-2:0] max_words,
  output logic [CNT_W:0]   rnd_bytes,
  output logic [CNT_W:0]   pad_bytes,
  output logic             same_words
);
  localparam int SUM_W = CNT_W + 1;
  localparam int WRD_W = CNT_W - 1;

  logic [SUM_W-1:0] max_sum;
  logic [SUM_W-1:0] len_sum;
  logic [WRD_W-1:0] len_words;

  always_comb begin
    max_sum    = {1'b0, max_pkt} + SUM_W'(3);
    len_sum    = {1'b0, pkt_len} + SUM_W'(3);
    max_words  = max_sum[SUM_W-1:2];
    len_words  = len_sum[SUM_W-1:2];
    rnd_bytes  = {max_words, 2'b00};
    pad_bytes  = rnd_bytes - {1'b0, pkt_len};
    same_words = (len_words == max_words);
  end

endmodule

// File: rtl/rxdu_pkt_ctrl.sv
module rxdu_pkt_ctrl
  import rxdu_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [CNT_W-1:0] pkt_bytes,
  input  logic             sw_clr,
  input  logic             rd_ok,
  input  logic [CNT_W-2:0] max_words,
  input  logic             same_words,
  output logic             rx_ready,
  output logic             words_pend,
  output logic [CNT_W-1:0] pkt_len,
  output pkt_end_t         pkt_end
);
  localparam int WRD_W = CNT_W - 1;

  logic             rdy_q, rdy_d;
  logic [WRD_W-1:0] wleft_q, wleft_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             len_en;
  logic             last_rd;

  always_comb begin
    last_rd = rd_ok && (wleft_q == WRD_W'(1));
    rdy_d   = rdy_q;
    wleft_d = wleft_q;
    len_en  = 1'b0;
    len_d   = pkt_bytes;
    if (sw_clr) begin
      rdy_d   = 1'b0;
      wleft_d = '0;
    end else if (rd_ok) begin
      wleft_d = wleft_q - WRD_W'(1);
      if (last_rd && same_words) begin
        rdy_d = 1'b0;
      end
    end else if (pkt_valid && !rdy_q) begin
      rdy_d   = 1'b1;
      wleft_d = max_words;
      len_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      wleft_q <= '0;
    end else begin
      rdy_q   <= rdy_d;
      wleft_q <= wleft_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  assign rx_ready         = rdy_q;
  assign words_pend       = (wleft_q != '0);
  assign pkt_len          = len_q;
  assign pkt_end.fire     = last_rd && !sw_clr;
  assign pkt_end.self_clr = same_words;

endmodule

// File: rtl/rxdu_xfer_ctrl.sv
module rxdu_xfer_ctrl
  import rxdu_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic [LEN_W-1:0] xfer_len,
  input  pkt_end_t         pkt_end,
  input  logic [CNT_W:0]   rnd_bytes,
  input  logic [CNT_W:0]   pad_bytes,
  input  irq_mode_e        mode,
  output logic             len_ok,
  output logic [CNT_W:0]   pad_cnt,
  output logic             irq
);
  localparam int EXT_W = (LEN_W > CNT_W + 1) ? LEN_W : CNT_W + 1;

  logic [LEN_W-1:0] rem_q, rem_d;
  logic             rem_en;
  logic [CNT_W:0]   pad_q;
  logic             irq_q, irq_d;
  logic [EXT_W-1:0] rem_ext, rnd_ext, rem_after;

  always_comb begin
    rem_ext   = EXT_W'(rem_q);
    rnd_ext   = EXT_W'(rnd_bytes);
    rem_after = rem_ext - rnd_ext;
    len_ok    = (rem_ext >= rnd_ext);
    rem_en    = 1'b0;
    rem_d     = rem_q;
    if (xfer_start) begin
      rem_en = 1'b1;
      rem_d  = xfer_len;
    end else if (pkt_end.fire) begin
      rem_en = 1'b1;
      rem_d  = LEN_W'(rem_after);
    end
    irq_d = 1'b0;
    if (pkt_end.fire) begin
      if (mode == IRQ_PER_PKT) begin
        irq_d = 1'b1;
      end else begin
        irq_d = (rem_after == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= '0;
    end else if (pkt_end.fire) begin
      pad_q <= pad_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign pad_cnt = pad_q;
  assign irq     = irq_q;

endmodule

// File: rtl/rxdu_top.sv
module rxdu_top
  import rxdu_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             pkt_valid,
  input  logic [CNT_W-1:0] pkt_bytes,
  input  logic             sw_clr,
  input  logic             dma_en,
  input  logic             dma_mode,
  input  logic             xfer_start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             word_rd,
  output logic             burst_req,
  output logic             rx_ready,
  output logic [CNT_W:0]   pad_cnt,
  output logic             irq
);

  logic [CNT_W-2:0] max_words;
  logic [CNT_W:0]   rnd_bytes;
  logic [CNT_W:0]   pad_bytes;
  logic             same_words;
  logic [CNT_W-1:0] pkt_len;
  logic             words_pend;
  logic             len_ok;
  logic             rd_ok;
  pkt_end_t         pkt_end;
  irq_mode_e        mode;

  assign mode      = irq_mode_e'(dma_mode);
  assign burst_req = dma_en && rx_ready && words_pend && len_ok;
  assign rd_ok     = burst_req && word_rd;

  rxdu_size_calc #(.CNT_W(CNT_W)) u_size (
    .max_pkt    (max_pkt),
    .pkt_len    (pkt_len),
    .max_words  (max_words),
    .rnd_bytes  (rnd_bytes),
    .pad_bytes  (pad_bytes),
    .same_words (same_words)
  );

  rxdu_pkt_ctrl #(.CNT_W(CNT_W)) u_pkt (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_valid  (pkt_valid),
    .pkt_bytes  (pkt_bytes),
    .sw_clr     (sw_clr),
    .rd_ok      (rd_ok),
    .max_words  (max_words),
    .same_words (same_words),
    .rx_ready   (rx_ready),
    .words_pend (words_pend),
    .pkt_len    (pkt_len),
    .pkt_end    (pkt_end)
  );

  rxdu_xfer_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_len   (xfer_len),
    .pkt_end    (pkt_end),
    .rnd_bytes  (rnd_bytes),
    .pad_bytes  (pad_bytes),
    .mode       (mode),
    .len_ok     (len_ok),
    .pad_cnt    (pad_cnt),
    .irq        (irq)
  );

endmodule

// File: rtl/rxdu_chk.sv
module rxdu_chk (
  input logic clk,
  input logic rst_n,
  input logic pkt_valid,
  input logic sw_clr,
  input logic dma_en,
  input logic word_rd,
  input logic burst_req,
  input logic rx_ready,
  input logic irq
);

  // R1
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> (dma_en && rx_ready));

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !burst_req);

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4
  ready_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> ($past(sw_clr) || ($past(word_rd) && $past(burst_req))));

  // R12
  ready_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(pkt_valid));

endmodule

bind rxdu_top rxdu_chk u_rxdu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_valid (pkt_valid),
  .sw_clr    (sw_clr),
  .dma_en    (dma_en),
  .word_rd   (word_rd),
  .burst_req (burst_req),
  .rx_ready  (rx_ready),
  .irq       (irq)
);

// File: tb/test_rxdu_top.sv
module test_rxdu_top;
  localparam int CNT_W = 11;
  localparam int LEN_W = 16;

  logic             clk;
  logic             rst_n;
  logic [CNT_W-1:0] max_pkt;
  logic             pkt_valid;
  logic [CNT_W-1:0] pkt_bytes;
  logic             sw_clr;
  logic             dma_en;
  logic             dma_mode;
  logic             xfer_start;
  logic [LEN_W-1:0] xfer_len;
  logic             word_rd;
  logic             burst_req;
  logic             rx_ready;
  logic [CNT_W:0]   pad_cnt;
  logic             irq;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 0;

  // behavioural model state
  int m_ready, m_words, m_len, m_remain, m_pad, m_irq;

  rxdu_top #(.CNT_W(CNT_W), .LEN_W(LEN_W)) i_rxdu_top (
    .clk(clk), .rst_n(rst_n), .max_pkt(max_pkt), .pkt_valid(pkt_valid),
    .pkt_bytes(pkt_bytes), .sw_clr(sw_clr), .dma_en(dma_en), .dma_mode(dma_mode),
    .xfer_start(xfer_start), .xfer_len(xfer_len), .word_rd(word_rd),
    .burst_req(burst_req), .rx_ready(rx_ready), .pad_cnt(pad_cnt), .irq(irq)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int rnd_sz(input int m);
    return ((m + 3) / 4) * 4;
  endfunction

  function automatic int m_req();
    return (dma_en && m_ready != 0 && m_words > 0 && m_remain >= rnd_sz(int'(max_pkt))) ? 1 : 0;
  endfunction

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated at each rising edge, compared 5 ns later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready = 0; m_words = 0; m_len = 0; m_remain = 0; m_pad = 0; m_irq = 0;
    end else begin
      int rq, rs, mw;
      rq = m_req();
      rs = rnd_sz(int'(max_pkt));
      mw = rs / 4;
      m_irq = 0;
      if (sw_clr) begin
        m_ready = 0; m_words = 0;
      end else if (rq != 0 && word_rd) begin
        m_words--;
        if (m_words == 0) begin
          m_pad = rs - m_len;
          if (!xfer_start) m_remain = m_remain - rs;
          if ((m_len + 3) / 4 == mw) m_ready = 0;
          m_irq = dma_mode ? ((m_remain - (xfer_start ? m_remain : 0) == 0) ? 0 : 0) : 1;
          if (dma_mode) m_irq = ((xfer_start ? 0 : m_remain) == 0 && !xfer_start) ? 1 : 0;
        end
      end else if (pkt_valid && m_ready == 0) begin
        m_ready = 1; m_len = int'(pkt_bytes); m_words = mw;
      end
      if (xfer_start) m_remain = int'(xfer_len);
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      expect_eq("R1 burst_req", int'(burst_req), m_req());
      expect_eq("R4 rx_ready", int'(rx_ready), m_ready);
      expect_eq("R6 pad_cnt", int'(pad_cnt), m_pad);
      expect_eq(dma_mode ? "R8 irq" : "R7 irq", int'(irq), m_irq);
      if (irq) irq_seen++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic give_pkt(input int b);
    @(negedge clk); pkt_valid = 1; pkt_bytes = CNT_W'(b);
    @(negedge clk); pkt_valid = 0;
  endtask

  task automatic rd(input int n);
    @(negedge clk); word_rd = 1;
    repeat (n) @(negedge clk);
    word_rd = 0;
  endtask

  task automatic start(input int len);
    @(negedge clk); xfer_start = 1; xfer_len = LEN_W'(len);
    @(negedge clk); xfer_start = 0;
  endtask

  task automatic clr();
    @(negedge clk); sw_clr = 1;
    @(negedge clk); sw_clr = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; max_pkt = 64; pkt_valid = 0; pkt_bytes = 0; sw_clr = 0;
    dma_en = 0; dma_mode = 0; xfer_start = 0; xfer_len = 0; word_rd = 0;
    #35;
    // R11 reset state
    expect_eq("R11 burst_req", int'(burst_req), 0);
    expect_eq("R11 rx_ready", int'(rx_ready), 0);
    expect_eq("R11 irq", int'(irq), 0);
    expect_eq("R11 pad_cnt", int'(pad_cnt), 0);
    @(negedge clk); rst_n = 1;

    // Scenario A: max 64, per-packet irq, 128 bytes
    dma_en = 1; start(128);
    give_pkt(64); rd(20); idle(2);
    expect_eq("R2 ready cleared after 16 reads", int'(rx_ready), 0);
    expect_eq("R7 one irq per packet", irq_seen, 1);
    give_pkt(61); rd(16); idle(2);
    expect_eq("R4 61 of 64 clears", int'(rx_ready), 0);
    expect_eq("R6 pad 3", int'(pad_cnt), 3);
    expect_eq("R7 second irq", irq_seen, 2);
    give_pkt(10); idle(2);
    expect_eq("R9 no request when length used up", int'(burst_req), 0);
    expect_eq("R9 packet held for software", int'(rx_ready), 1);
    clr(); idle(1);
    expect_eq("R5 sw_clr drops ready", int'(rx_ready), 0);

    // Scenario B: max 61 (rounds to 64), end-of-transfer irq, 128 bytes
    irq_seen = 0; max_pkt = 61; dma_mode = 1; start(128);
    give_pkt(61); rd(16); idle(2);
    expect_eq("R8 no irq mid transfer", irq_seen, 0);
    expect_eq("R4 full packet clears", int'(rx_ready), 0);
    give_pkt(60); rd(16); idle(2);
    expect_eq("R3 two rounded packets end 128", irq_seen, 1);
    expect_eq("R4 60 of 61 keeps ready", int'(rx_ready), 1);
    expect_eq("R6 pad 4", int'(pad_cnt), 4);
    expect_eq("R2 no request after last word", int'(burst_req), 0);
    clr();

    // Scenario C: max 62, per-packet, repeated ready pulse ignored
    irq_seen = 0; max_pkt = 62; dma_mode = 0; start(256);
    give_pkt(60); give_pkt(62); rd(16); idle(2);
    expect_eq("R12 second pulse ignored, pad", int'(pad_cnt), 4);
    expect_eq("R4 60 of 62 keeps ready", int'(rx_ready), 1);
    clr();
    give_pkt(61); rd(16); idle(2);
    expect_eq("R4 61 of 62 clears", int'(rx_ready), 0);
    expect_eq("R6 pad 3 for 61", int'(pad_cnt), 3);

    // Scenario D: max 8, disable mid-burst and software abort
    irq_seen = 0; max_pkt = 8; start(64);
    give_pkt(8); rd(1);
    @(negedge clk); dma_en = 0; #1;
    expect_eq("R10 request drops with enable", int'(burst_req), 0);
    rd(3); idle(2);
    expect_eq("R10 no irq while disabled", irq_seen, 0);
    @(negedge clk); dma_en = 1;
    rd(1); idle(2);
    expect_eq("R7 irq after resumed word", irq_seen, 1);
    give_pkt(8); rd(1);
    @(negedge clk); sw_clr = 1; word_rd = 1;
    @(negedge clk); sw_clr = 0; word_rd = 0; idle(2);
    expect_eq("R5 abort gives no irq", irq_seen, 1);
    expect_eq("R5 abort clears ready", int'(rx_ready), 0);

    // R13: reload length in the clock of a completion
    give_pkt(8);
    @(negedge clk); word_rd = 1;
    @(negedge clk);
    xfer_start = 1; xfer_len = 8;
    @(negedge clk); word_rd = 0; xfer_start = 0;
    give_pkt(8); idle(1);
    expect_eq("R13 reload wins over decrement", int'(burst_req), 1);
    rd(2); idle(2);
    give_pkt(8); idle(1);
    expect_eq("R13 reloaded length consumed", int'(burst_req), 0);

    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule